// File: doc/BRIEF.md
# Serial Clock and Battery-RAM Chip Interface

This block is the device side of a three-wire serial clock chip that a host drives bit by bit through a control register: a chip-select line, a serial clock and a serial data line. Every transfer has sixteen bits. The first eight bits are a command byte, sent most significant bit first. The last eight bits are a data byte. A command can write the data byte into the chip, or it can make the chip return a byte on the data line during the last eight bits.

The chip holds 32 bytes of battery RAM, a status byte and a control byte. The battery RAM resets to a fixed image that is given as a parameter. Time of day is not kept inside the block. The host supplies seconds, minutes, hours, day of month, month and year as packed BCD on input ports, and the chip returns them on read commands. One write command acknowledges a pending event: it clears two status flags and sends a one-cycle pulse that clears the matching bit in the host's interrupt status.

All three wires are sampled on the system clock. A falling edge of the serial clock is found by comparing the current sample with the previous one. The bit returned on each such edge appears on `sdo_o`, where the host reads the data line back. The last eight bits returned by read commands are also kept on `retval_o`.

Top module: `rtc_serial_if`

## Requirements
- R1: After reset, `sdo_o`, `retval_o` and `irq_clr_o` are all 0.
- R2: Commands 0x00–0x1F return the RAM byte at that address. On the falling edges of bits 8..15, the byte appears on `sdo_o` most significant bit first. After the transfer, `retval_o` holds that byte. After reset, byte i of the RAM is bits [8i+7:8i] of the image parameter.
- R3: Commands 0x80–0x9F store the data byte at RAM address (command − 0x80). The write happens on the falling edge of the 16th bit.
- R4: Command 0x30 returns the status byte. The status byte resets to 0x90.
- R5: Command 0x31 returns the control byte, which equals the control parameter.
- R6: Command 0x20 returns seconds, 0x21 minutes, 0x22 hours, 0x24 day of month, 0x25 month and 0x26 year, each taken from the BCD input ports. Every other code from 0x20 to 0x2F returns 0x00.
- R7: Command 0xB1 with data bit 2 set clears status bits 3 and 4. It also pulses `irq_clr_o` high for exactly one cycle, starting from the 16th falling edge. If data bit 2 is clear, this command changes nothing.
- R8: While chip select is low, the transfer is aborted: the bit counter returns to 0, and the command and data shift registers are cleared. An aborted transfer writes nothing.
- R9: Only a falling edge of the serial clock, with chip select high, advances the transfer. Rising edges, and a serial clock held at one level, leave `sdo_o` unchanged.
- R10: The bit counter stops at 16. Further falling edges before chip select drops have no effect: they change neither `sdo_o` nor the RAM.
- R11: In every phase that is not a read phase, `sdo_o` echoes the sampled data bit on each falling edge. This covers bits 0..7, and bits 8..15 of commands that are not reads. In those phases `retval_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Chip select; low aborts the transfer |
| sclk_i | input | 1 | Serial clock; falling edges advance the transfer |
| sdio_i | input | 1 | Serial data written by the host |
| sec_i | input | 8 | Seconds, BCD |
| min_i | input | 8 | Minutes, BCD |
| hour_i | input | 8 | Hours, BCD |
| mday_i | input | 8 | Day of month, BCD |
| month_i | input | 8 | Month 1..12, BCD |
| year_i | input | 8 | Year minus 2000, BCD |
| sdo_o | output | 1 | Data-line readback bit |
| retval_o | output | 8 | Last eight bits returned by read commands |
| irq_clr_o | output | 1 | One-cycle pulse that clears host interrupt status bit 2 |

## Verification
A wrong bit counter shows up first on `sdo_o`, on the very next falling edge. A transfer that is off by one phase either echoes a bit where a returned bit belongs, or shifts the returned byte by one position, so the first read after the fault gives a wrong byte. Faults in the RAM or the status byte stay hidden until a later read command selects that byte; the bench therefore reads back every byte it writes or clears. An aborted or over-clocked transfer that writes by mistake is caught by reading the affected address in the next transfer.

// File: rtl/rtc_serial_pkg.sv
package rtc_serial_pkg;

    localparam int BYTE_W     = 8;
    localparam int RAM_DEPTH  = 32;
    localparam int RAM_AW     = $clog2(RAM_DEPTH);
    localparam int XFER_BITS  = 2 * BYTE_W;
    localparam int PHASE_W    = $clog2(XFER_BITS + 1);

    localparam logic [7:0] CMD_STATUS  = 8'h30;
    localparam logic [7:0] CMD_CONTROL = 8'h31;
    localparam logic [7:0] CMD_ACK     = 8'hB1;
    localparam logic [7:0] STATUS_INIT = 8'h90;
    localparam logic [7:0] ACK_CLEAR   = 8'h18;
    localparam int         ACK_BIT     = 2;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] mday;
        logic [7:0] month;
        logic [7:0] year;
    } bcd_time_t;

    typedef enum logic [2:0] {
        SRC_RAM,
        SRC_TIME,
        SRC_STATUS,
        SRC_CONTROL,
        SRC_NONE
    } rd_src_e;

    function automatic rd_src_e classify(input logic [7:0] cmd);
        if (cmd[7:5] == 3'b000)      return SRC_RAM;
        else if (cmd[7:4] == 4'h2)   return SRC_TIME;
        else if (cmd == CMD_STATUS)  return SRC_STATUS;
        else if (cmd == CMD_CONTROL) return SRC_CONTROL;
        else                         return SRC_NONE;
    endfunction

    function automatic logic [7:0] time_field(input logic [3:0] sel, input bcd_time_t t);
        case (sel)
            4'h0:    return t.sec;
            4'h1:    return t.min;
            4'h2:    return t.hour;
            4'h4:    return t.mday;
            4'h5:    return t.month;
            4'h6:    return t.year;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic is_ram_write(input logic [7:0] cmd);
        return cmd[7:5] == 3'b100;
    endfunction

endpackage

// File: rtl/rtc_shift.sv
module rtc_shift
    import rtc_serial_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ce,
    input  logic               sclk,
    input  logic               sdi,
    output logic [PHASE_W-1:0] phase_o,
    output logic [BYTE_W-1:0]  cmd_o,
    output logic [BYTE_W-1:0]  val_next_o,
    output logic               step_o,
    output logic               commit_o
);

    localparam logic [PHASE_W-1:0] DONE = PHASE_W'(XFER_BITS);
    localparam logic [PHASE_W-1:0] LAST = PHASE_W'(XFER_BITS - 1);
    localparam logic [PHASE_W-1:0] HALF = PHASE_W'(BYTE_W);

    logic               sclk_q;
    logic [PHASE_W-1:0] phase_q;
    logic [BYTE_W-1:0]  cmd_q;
    logic [BYTE_W-1:0]  val_q;

    assign step_o     = ce && sclk_q && !sclk && (phase_q < DONE);
    assign commit_o   = step_o && (phase_q == LAST);
    assign val_next_o = {val_q[BYTE_W-2:0], sdi};
    assign phase_o    = phase_q;
    assign cmd_o      = cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            phase_q <= '0;
            cmd_q   <= '0;
            val_q   <= '0;
        end else begin
            sclk_q <= sclk;
            if (!ce) begin
                phase_q <= '0;
                cmd_q   <= '0;
                val_q   <= '0;
            end else if (step_o) begin
                phase_q <= phase_q + 1'b1;
                if (phase_q < HALF) cmd_q <= {cmd_q[BYTE_W-2:0], sdi};
                else                val_q <= val_next_o;
            end
        end
    end

endmodule

// File: rtl/rtc_store.sv
module rtc_store
    import rtc_serial_pkg::*;
#(
    parameter logic [RAM_DEPTH*BYTE_W-1:0] RAM_IMAGE = '0,
    parameter logic [BYTE_W-1:0]           CTRL_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [BYTE_W-1:0] cmd,
    input  logic [BYTE_W-1:0] wval,
    input  bcd_time_t         now,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              rd_hit,
    output logic              irq_clr_o
);

    logic [BYTE_W-1:0] ram_q [RAM_DEPTH];
    logic [BYTE_W-1:0] status_q;
    logic              irq_q;
    rd_src_e           src;

    assign src = classify(cmd);

    always_comb begin
        rd_hit  = 1'b1;
        rd_byte = '0;
        case (src)
            SRC_RAM:     rd_byte = ram_q[cmd[RAM_AW-1:0]];
            SRC_TIME:    rd_byte = time_field(cmd[3:0], now);
            SRC_STATUS:  rd_byte = status_q;
            SRC_CONTROL: rd_byte = CTRL_INIT;
            default:     rd_hit  = 1'b0;
        endcase
    end

    for (genvar g = 0; g < RAM_DEPTH; g++) begin : g_ram
        always_ff @(posedge clk) begin
            if (rst)
                ram_q[g] <= RAM_IMAGE[g*BYTE_W +: BYTE_W];
            else if (commit && is_ram_write(cmd) && cmd[RAM_AW-1:0] == RAM_AW'(g))
                ram_q[g] <= wval;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= STATUS_INIT;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (commit && cmd == CMD_ACK && wval[ACK_BIT]) begin
                status_q <= status_q & ~ACK_CLEAR;
                irq_q    <= 1'b1;
            end
        end
    end

    assign irq_clr_o = irq_q;

endmodule

// File: rtl/rtc_serial_if.sv
module rtc_serial_if
    import rtc_serial_pkg::*;
#(
    parameter logic [RAM_DEPTH*BYTE_W-1:0] RAM_IMAGE =
        256'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F_C0FFEE00_5AA5A55A_13579BDF_2468ACE0,
    parameter logic [BYTE_W-1:0] CTRL_INIT = 8'h4A
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_i,
    input  logic       sclk_i,
    input  logic       sdio_i,
    input  logic [7:0] sec_i,
    input  logic [7:0] min_i,
    input  logic [7:0] hour_i,
    input  logic [7:0] mday_i,
    input  logic [7:0] month_i,
    input  logic [7:0] year_i,
    output logic       sdo_o,
    output logic [7:0] retval_o,
    output logic       irq_clr_o
);

    logic [PHASE_W-1:0] phase;
    logic [BYTE_W-1:0]  cmd;
    logic [BYTE_W-1:0]  val_next;
    logic               step;
    logic               commit;
    logic [BYTE_W-1:0]  rd_byte;
    logic               rd_hit;
    logic               rd_phase;
    logic               out_bit;
    bcd_time_t          now;
    logic               sdo_q;
    logic [BYTE_W-1:0]  ret_q;

    assign now = '{sec: sec_i, min: min_i, hour: hour_i,
                   mday: mday_i, month: month_i, year: year_i};

    rtc_shift i_shift (
        .clk        (clk),
        .rst        (rst),
        .ce         (ce_i),
        .sclk       (sclk_i),
        .sdi        (sdio_i),
        .phase_o    (phase),
        .cmd_o      (cmd),
        .val_next_o (val_next),
        .step_o     (step),
        .commit_o   (commit)
    );

    rtc_store #(.RAM_IMAGE(RAM_IMAGE), .CTRL_INIT(CTRL_INIT)) i_store (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .cmd       (cmd),
        .wval      (val_next),
        .now       (now),
        .rd_byte   (rd_byte),
        .rd_hit    (rd_hit),
        .irq_clr_o (irq_clr_o)
    );

    assign rd_phase = (phase >= PHASE_W'(BYTE_W)) && (phase < PHASE_W'(XFER_BITS)) && rd_hit;
    assign out_bit  = rd_byte[3'(~phase[2:0])];

    always_ff @(posedge clk) begin
        if (rst) begin
            sdo_q <= 1'b0;
            ret_q <= '0;
        end else if (step) begin
            if (rd_phase) begin
                sdo_q <= out_bit;
                ret_q <= {ret_q[BYTE_W-2:0], out_bit};
            end else begin
                sdo_q <= sdio_i;
            end
        end
    end

    assign sdo_o    = sdo_q;
    assign retval_o = ret_q;

endmodule

// File: rtl/rtc_serial_checker.sv
module rtc_serial_checker (
    input logic       clk,
    input logic       rst,
    input logic       ce_i,
    input logic       sclk_i,
    input logic       sdo_o,
    input logic [7:0] retval_o,
    input logic       irq_clr_o,
    input logic [4:0] phase
);

    logic sclk_prev;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b0;
        else     sclk_prev <= sclk_i;
    end

    assign fall = ce_i && sclk_prev && !sclk_i;

    p_phase_bound_r10: assert property (@(posedge clk) disable iff (rst)
        phase <= 5'd16);

    p_sdo_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(sdo_o));

    p_retval_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(retval_o));

    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        irq_clr_o |=> !irq_clr_o);

    p_irq_at_end_r7: assert property (@(posedge clk) disable iff (rst)
        irq_clr_o |-> phase == 5'd16);

    p_abort_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !ce_i |=> phase == 5'd0);

endmodule

bind rtc_serial_if rtc_serial_checker i_rtc_serial_checker (
    .clk       (clk),
    .rst       (rst),
    .ce_i      (ce_i),
    .sclk_i    (sclk_i),
    .sdo_o     (sdo_o),
    .retval_o  (retval_o),
    .irq_clr_o (irq_clr_o),
    .phase     (phase)
);

// File: tb/test_rtc_serial_if.sv
module test_rtc_serial_if;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce_i = 1'b0;
    logic       sclk_i = 1'b0;
    logic       sdio_i = 1'b0;
    logic [7:0] sec_i = 8'h59, min_i = 8'h07, hour_i = 8'h23;
    logic [7:0] mday_i = 8'h31, month_i = 8'h12, year_i = 8'h24;
    logic       sdo_o;
    logic [7:0] retval_o;
    logic       irq_clr_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #10ns clk = ~clk;

    rtc_serial_if i_rtc_serial_if (
        .clk(clk), .rst(rst), .ce_i(ce_i), .sclk_i(sclk_i), .sdio_i(sdio_i),
        .sec_i(sec_i), .min_i(min_i), .hour_i(hour_i), .mday_i(mday_i),
        .month_i(month_i), .year_i(year_i),
        .sdo_o(sdo_o), .retval_o(retval_o), .irq_clr_o(irq_clr_o)
    );

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] wval;
        logic [7:0] exp;
        logic       rd;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 8'h00, 8'hE0, 1'b1},   // R2 RAM byte 0
        '{8'h1F, 8'hFF, 8'hF0, 1'b1},   // R2 RAM byte 31
        '{8'h0D, 8'h00, 8'hEE, 1'b1},   // R2 RAM byte 13
        '{8'h20, 8'h00, 8'h59, 1'b1},   // R6 seconds
        '{8'h21, 8'h00, 8'h07, 1'b1},   // R6 minutes
        '{8'h22, 8'h00, 8'h23, 1'b1},   // R6 hours
        '{8'h23, 8'hFF, 8'h00, 1'b1},   // R6 unused code
        '{8'h24, 8'h00, 8'h31, 1'b1},   // R6 day of month
        '{8'h25, 8'h00, 8'h12, 1'b1},   // R6 month
        '{8'h26, 8'h00, 8'h24, 1'b1},   // R6 year
        '{8'h2F, 8'h00, 8'h00, 1'b1},   // R6 unused code
        '{8'h30, 8'h00, 8'h90, 1'b1},   // R4 status reset value
        '{8'h31, 8'h00, 8'h4A, 1'b1},   // R5 control byte
        '{8'h85, 8'h3C, 8'h3C, 1'b0},   // R3 write, R11 echo
        '{8'h05, 8'h00, 8'h3C, 1'b1},   // R3 readback
        '{8'h9F, 8'hA6, 8'hA6, 1'b0},   // R3 write top address
        '{8'h1F, 8'h00, 8'hA6, 1'b1},   // R3 readback
        '{8'h40, 8'h5B, 8'h5B, 1'b0},   // R11 non-read command echoes
        '{8'h03, 8'h00, 8'h24, 1'b1}    // R2 RAM byte 3
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bit: raise sclk with data, lower it, sample after the detecting edge.
    task automatic send_bit(input logic b, output logic sdo_seen, output logic irq_seen);
        sclk_i = 1'b1;
        sdio_i = b;
        @(negedge clk);
        sclk_i = 1'b0;
        @(negedge clk);
        sdo_seen = sdo_o;
        irq_seen = irq_clr_o;
    endtask

    task automatic xfer(input logic [7:0] cmd, input logic [7:0] wval,
                        output logic [7:0] rd, output logic irq_end);
        logic s, q;
        @(negedge clk);
        ce_i = 1'b1;
        for (int i = 7; i >= 0; i--) send_bit(cmd[i], s, q);
        for (int i = 7; i >= 0; i--) begin
            send_bit(wval[i], s, q);
            rd[i] = s;
        end
        irq_end = q;
        ce_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] rd;
        logic       irq, s, q;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 sdo after reset", sdo_o, 1'b0);
        check("R1 retval after reset", retval_o, 8'h00);
        check("R1 irq_clr after reset", irq_clr_o, 1'b0);

        for (int v = 0; v < NVEC; v++) begin
            xfer(VECS[v].cmd, VECS[v].wval, rd, irq);
            check($sformatf("vector %0d cmd %0h data line", v, VECS[v].cmd), rd, VECS[v].exp);
            if (VECS[v].rd)
                check($sformatf("vector %0d R2 retval", v), retval_o, VECS[v].exp);
            else
                check($sformatf("vector %0d R11 retval kept", v), retval_o, VECS[v-1].exp);
        end

        // R7: acknowledge without bit 2 does nothing
        xfer(8'hB1, 8'h00, rd, irq);
        check("R7 no pulse without bit 2", irq, 1'b0);
        xfer(8'h30, 8'h00, rd, irq);
        check("R7 status kept", rd, 8'h90);
        // R7: acknowledge with bit 2
        xfer(8'hB1, 8'h04, rd, irq);
        check("R7 pulse at 16th edge", irq, 1'b1);
        check("R7 pulse is one cycle", irq_clr_o, 1'b0);
        xfer(8'h30, 8'h00, rd, irq);
        check("R7 status flags cleared", rd, 8'h80);

        // R8: abort a write to 0x83 after 12 bits, then a fresh read works
        @(negedge clk);
        ce_i = 1'b1;
        for (int i = 7; i >= 0; i--) send_bit(logic'((8'h83 >> i) & 1), s, q);
        for (int i = 0; i < 4; i++) send_bit(1'b1, s, q);
        ce_i = 1'b0;
        @(negedge clk);
        xfer(8'h03, 8'h00, rd, irq);
        check("R8 aborted write leaves RAM", rd, 8'h24);

        // R10: extra edges after bit 16 change nothing
        @(negedge clk);
        ce_i = 1'b1;
        for (int i = 7; i >= 0; i--) send_bit(logic'((8'h86 >> i) & 1), s, q);
        for (int i = 7; i >= 0; i--) send_bit(logic'((8'h11 >> i) & 1), s, q);
        for (int i = 0; i < 4; i++) begin
            send_bit(1'b0, s, q);
            check("R10 sdo frozen after bit 16", s, 1'b1);
        end
        ce_i = 1'b0;
        @(negedge clk);
        xfer(8'h06, 8'h00, rd, irq);
        check("R10 extra edges did not rewrite", rd, 8'h11);

        // R9: rising edge and held clock do not advance
        @(negedge clk);
        ce_i = 1'b1;
        send_bit(1'b1, s, q);
        check("R9 echo of first bit", s, 1'b1);
        sclk_i = 1'b1;
        sdio_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 sdo held while sclk high", sdo_o, 1'b1);
        sclk_i = 1'b0;
        @(negedge clk);
        check("R9 falling edge advances", sdo_o, 1'b0);
        ce_i = 1'b0;
        @(negedge clk);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #2ms;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule